// File: doc/BRIEF.md
# NCO Complex I/Q Up-Converter

This block shifts a complex baseband stream up to an intermediate frequency before two real converters. Each accepted sample pair (I, Q) is rotated by the phase of a numerically controlled oscillator. A 32-bit phase accumulator advances by the tuning word once for every valid sample, so the output frequency is the tuning word divided by 2^32, times the update rate. A 16-bit phase offset is added to the top half of the accumulator. The top six bits of that sum address a sine table built inside the block. The table stores one quarter wave with 17 entries and is mirrored for the other three quadrants.

A 3-bit mode selects the mixing. Mode 000 is a plain pass-through. Mode 001 gives upper-sideband mixing and mode 010 gives lower-sideband mixing. The products are rounded and saturated back to the sample width. With the oscillator disabled, the accumulator is held at zero and the data takes the pass-through path.

Top module: `nco_iq_mixer`

## Requirements
- R1: While rst_n is low and after it is released, out_vld, out_a and out_b are 0 and the phase accumulator is 0.
- R2: out_vld goes high exactly two clock cycles after in_vld is sampled high, and is low otherwise. out_a and out_b change only on cycles in which out_vld goes high.
- R3: In mode 3'b000 with nco_en high, out_a equals in_i and out_b equals in_q, bit for bit.
- R4: In mode 3'b001, out_a ≈ I·cos θ − Q·sin θ and out_b ≈ I·sin θ + Q·cos θ, within 1 LSB.
- R5: In mode 3'b010, out_a ≈ I·cos θ + Q·sin θ and out_b ≈ −I·sin θ + Q·cos θ, within 1 LSB. The sine terms are negated relative to R4.
- R6: Modes 3'b011 to 3'b111 behave exactly as mode 3'b000.
- R7: θ = 2π·k/64, where k is bits [15:10] of (acc[31:16] + phase_ofs) mod 2^16. acc is the sum of ftw over all earlier valid samples since reset or since the last disabled cycle, mod 2^32. Cycles without in_vld leave acc unchanged.
- R8: A cycle with nco_en low clears acc. While nco_en is low, samples pass through unmixed in every mode.
- R9: A mixed result outside the signed DW-bit range is clamped to −2^(DW−1) or 2^(DW−1)−1.
- R10: phase_ofs rotates the result. With ftw = 0, phase_ofs = 16'h4000 gives θ = 90°, so out_a = −Q and out_b = I in mode 3'b001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nco_en | input | 1 | Oscillator enable; low clears accumulator and forces pass-through |
| mode | input | 3 | 000 pass, 001 upper sideband, 010 lower sideband, others pass |
| ftw | input | 32 | Frequency tuning word |
| phase_ofs | input | 16 | Phase offset added to the accumulator top half |
| in_vld | input | 1 | Input sample strobe |
| in_i | input | DW | In-phase sample, signed |
| in_q | input | DW | Quadrature sample, signed |
| out_vld | output | 1 | Output strobe |
| out_a | output | DW | Channel A result, signed |
| out_b | output | DW | Channel B result, signed |

## Verification
The block has two register stages, so every result is due two rising edges after the edge that samples in_vld. This holds in all modes, with the pass-through path delayed to match the mixing path. The bench drives inputs on a falling edge and checks the outputs on the second falling edge after that. One edge later it confirms that out_vld has dropped and the outputs have held. The bench keeps its own copy of the accumulator, advanced once per issued sample and cleared on disabled cycles. From it, the bench derives the table angle of each sample with real-valued trigonometry.

// File: rtl/nco_iq_mixer.sv
module nco_iq_mixer #(
  parameter int DW = 10,
  parameter int FW = 32,
  parameter int PW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 nco_en,
  input  logic [2:0]           mode,
  input  logic [FW-1:0]        ftw,
  input  logic [PW-1:0]        phase_ofs,
  input  logic                 in_vld,
  input  logic signed [DW-1:0] in_i,
  input  logic signed [DW-1:0] in_q,
  output logic                 out_vld,
  output logic signed [DW-1:0] out_a,
  output logic signed [DW-1:0] out_b
);
  localparam int AW = 6;
  localparam int CW = 16;
  localparam int XW = DW + CW + 1;
  localparam logic signed [XW-1:0] HALF = XW'(1 << (CW - 2));
  localparam logic signed [XW-1:0] MAXV = XW'((1 << (DW - 1)) - 1);
  localparam logic signed [XW-1:0] MINV = -XW'(1 << (DW - 1));

  logic [FW-1:0] acc;
  logic [PW-1:0] ph;
  logic [AW-1:0] idx;
  logic          mix, lsb;

  assign ph  = acc[FW-1 -: PW] + phase_ofs;
  assign idx = ph[PW-1 -: AW];
  assign lsb = (mode == 3'b010);
  assign mix = nco_en && (mode == 3'b001 || lsb);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       acc <= '0;
    else if (!nco_en) acc <= '0;
    else if (in_vld)  acc <= acc + ftw;

  function automatic logic signed [CW-1:0] qsin(input logic [AW-1:0] a);
    logic [4:0] f;
    logic signed [CW-1:0] m;
    f = a[4] ? 5'd16 - {1'b0, a[3:0]} : {1'b0, a[3:0]};
    case (f)
      5'd0:  m = 16'sd0;
      5'd1:  m = 16'sd3212;
      5'd2:  m = 16'sd6393;
      5'd3:  m = 16'sd9512;
      5'd4:  m = 16'sd12539;
      5'd5:  m = 16'sd15446;
      5'd6:  m = 16'sd18204;
      5'd7:  m = 16'sd20787;
      5'd8:  m = 16'sd23170;
      5'd9:  m = 16'sd25329;
      5'd10: m = 16'sd27245;
      5'd11: m = 16'sd28898;
      5'd12: m = 16'sd30273;
      5'd13: m = 16'sd31356;
      5'd14: m = 16'sd32137;
      5'd15: m = 16'sd32609;
      default: m = 16'sd32767;
    endcase
    return a[5] ? -m : m;
  endfunction

  logic                 s1_vld, s1_mix;
  logic signed [DW-1:0] s1_i, s1_q;
  logic signed [CW-1:0] s1_sin, s1_cos;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1_vld <= 1'b0; s1_mix <= 1'b0;
      s1_i <= '0; s1_q <= '0; s1_sin <= '0; s1_cos <= '0;
    end else begin
      s1_vld <= in_vld;
      if (in_vld) begin
        s1_mix <= mix;
        s1_i   <= in_i;
        s1_q   <= in_q;
        s1_sin <= lsb ? -qsin(idx) : qsin(idx);
        s1_cos <= qsin(idx + AW'(16));
      end
    end

  logic signed [XW-1:0] xi, xq, xs, xc, pa, pb, ra, rb;
  assign xi = {{(XW-DW){s1_i[DW-1]}}, s1_i};
  assign xq = {{(XW-DW){s1_q[DW-1]}}, s1_q};
  assign xs = {{(XW-CW){s1_sin[CW-1]}}, s1_sin};
  assign xc = {{(XW-CW){s1_cos[CW-1]}}, s1_cos};
  assign pa = xi * xc - xq * xs;
  assign pb = xi * xs + xq * xc;
  assign ra = (pa + HALF) >>> (CW - 1);
  assign rb = (pb + HALF) >>> (CW - 1);

  function automatic logic signed [DW-1:0] sat(input logic signed [XW-1:0] v);
    if (v > MAXV)      return MAXV[DW-1:0];
    else if (v < MINV) return MINV[DW-1:0];
    else               return v[DW-1:0];
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      out_vld <= 1'b0; out_a <= '0; out_b <= '0;
    end else begin
      out_vld <= s1_vld;
      if (s1_vld) begin
        out_a <= s1_mix ? sat(ra) : s1_i;
        out_b <= s1_mix ? sat(rb) : s1_q;
      end
    end
endmodule

// File: rtl/nco_iq_mixer_chk.sv
module nco_iq_mixer_chk #(
  parameter int DW = 10,
  parameter int FW = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 nco_en,
  input logic [2:0]           mode,
  input logic [FW-1:0]        ftw,
  input logic [FW-1:0]        acc,
  input logic                 in_vld,
  input logic signed [DW-1:0] in_i,
  input logic signed [DW-1:0] in_q,
  input logic                 out_vld,
  input logic signed [DW-1:0] out_a,
  input logic signed [DW-1:0] out_b
);
  logic [1:0] cnt;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt <= '0;
    else if (cnt != 2'd3) cnt <= cnt + 2'd1;

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt == 2'd1 |-> !out_vld && out_a == '0 && out_b == '0) else $error("AST_RESET_STATE"); // R1
  AST_ACC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !nco_en |=> acc == '0) else $error("AST_ACC_CLEAR"); // R8
  AST_ACC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    nco_en && in_vld |=> acc == $past(acc) + $past(ftw)) else $error("AST_ACC_STEP"); // R7
  AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    nco_en && !in_vld |=> $stable(acc)) else $error("AST_ACC_HOLD"); // R7
  AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    cnt == 2'd3 |-> out_vld == $past(in_vld, 2)) else $error("AST_OUT_LATENCY"); // R2
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cnt != 2'd0 && !out_vld |-> $stable(out_a) && $stable(out_b)) else $error("AST_OUT_HOLD"); // R2
  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    cnt == 2'd3 && $past(in_vld && (!nco_en || !(mode == 3'b001 || mode == 3'b010)), 2)
    |-> out_a == $past(in_i, 2) && out_b == $past(in_q, 2)) else $error("AST_PASS_THROUGH"); // R3 R6 R8
endmodule

bind nco_iq_mixer nco_iq_mixer_chk #(.DW(DW), .FW(FW)) u_chk (
  .clk(clk), .rst_n(rst_n), .nco_en(nco_en), .mode(mode), .ftw(ftw), .acc(acc),
  .in_vld(in_vld), .in_i(in_i), .in_q(in_q),
  .out_vld(out_vld), .out_a(out_a), .out_b(out_b)
);

// File: tb/nco_iq_mixer_tb.sv
module nco_iq_mixer_tb;
  localparam int DW = 10;
  localparam real PI = 3.14159265358979;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic nco_en = 1'b0;
  logic [2:0] mode = 3'b000;
  logic [31:0] ftw = '0;
  logic [15:0] phase_ofs = '0;
  logic in_vld = 1'b0;
  logic signed [DW-1:0] in_i = '0, in_q = '0;
  logic out_vld;
  logic signed [DW-1:0] out_a, out_b;

  int vectors = 0, miscompares = 0;
  logic [31:0] macc = '0;

  always #2 clk = ~clk;

  nco_iq_mixer #(.DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .nco_en(nco_en), .mode(mode), .ftw(ftw),
    .phase_ofs(phase_ofs), .in_vld(in_vld), .in_i(in_i), .in_q(in_q),
    .out_vld(out_vld), .out_a(out_a), .out_b(out_b)
  );

  task automatic chk_exact(string r, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic chk_near(string r, int act, real exp);
    real d;
    vectors++;
    d = real'(act) - exp;
    if (d > 1.0 || d < -1.0) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%f", r, act, exp);
    end
  endtask

  function automatic real clampr(real v);
    real hi, lo;
    hi = real'((1 << (DW - 1)) - 1);
    lo = -real'(1 << (DW - 1));
    return v > hi ? hi : (v < lo ? lo : v);
  endfunction

  // one sample: drive, wait two edges, check, then check the hold cycle
  task automatic send(string r, int i, int q);
    logic [15:0] ph;
    real th, ea, eb;
    int pa, pb;
    bit mixing, lower;
    ph = macc[31:16] + phase_ofs;
    th = 2.0 * PI * real'(ph[15:10]) / 64.0;
    mixing = nco_en && (mode == 3'b001 || mode == 3'b010);
    lower = (mode == 3'b010);
    ea = real'(i) * $cos(th) - (lower ? -1.0 : 1.0) * real'(q) * $sin(th);
    eb = (lower ? -1.0 : 1.0) * real'(i) * $sin(th) + real'(q) * $cos(th);
    in_i = DW'(i); in_q = DW'(q); in_vld = 1'b1;
    if (nco_en) macc = macc + ftw;
    @(negedge clk) in_vld = 1'b0;
    @(negedge clk);
    chk_exact({r, " out_vld R2"}, int'(out_vld), 1);
    if (mixing) begin
      chk_near({r, " chan A"}, int'(out_a), clampr(ea));
      chk_near({r, " chan B"}, int'(out_b), clampr(eb));
    end else begin
      chk_exact({r, " chan A"}, int'(out_a), i);
      chk_exact({r, " chan B"}, int'(out_b), q);
    end
    pa = int'(out_a); pb = int'(out_b);
    @(negedge clk);
    chk_exact({r, " out_vld low R2"}, int'(out_vld), 0);
    chk_exact({r, " hold A R2"}, int'(out_a), pa);
    chk_exact({r, " hold B R2"}, int'(out_b), pb);
  endtask

  task automatic disable_nco();
    nco_en = 1'b0;
    @(negedge clk);
    macc = '0;
  endtask

  initial begin
    #(4 * 200000);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_exact("R1 out_vld in reset", int'(out_vld), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_exact("R1 out_vld", int'(out_vld), 0);
    chk_exact("R1 out_a", int'(out_a), 0);
    chk_exact("R1 out_b", int'(out_b), 0);

    nco_en = 1'b1; ftw = 32'h0123_4567; mode = 3'b000;
    @(negedge clk);
    // R3 sweep, accumulator runs underneath
    for (int i = -512; i < 512; i += 37)
      for (int q = -512; q < 512; q += 53) send("R3 pass", i, q);
    send("R3 max", 511, -512);

    // R6 unused modes
    for (int m = 3; m < 8; m++) begin
      mode = 3'(m);
      send("R6 unused mode", -300 + 50 * m, 211 - 17 * m);
    end

    // R8 disable: pass-through in mixing modes
    disable_nco();
    mode = 3'b001;
    send("R8 disabled usb", 123, -77);
    mode = 3'b010;
    send("R8 disabled lsb", -400, 390);

    // R7 one table step per sample, from zero after re-enable
    nco_en = 1'b1; ftw = 32'h0400_0000; phase_ofs = '0; mode = 3'b001;
    @(negedge clk);
    for (int k = 0; k < 64; k++) send("R4 R7 step", 400, 0);
    // idle cycles must not advance the phase
    repeat (5) @(negedge clk);
    send("R7 after idle", 0, 300);

    // R4 / R5 sweeps over angle and data
    foreach (ftw[b]) ; // no-op
    ftw = 32'h0A3D_70A4;
    for (int m = 1; m < 3; m++) begin
      mode = 3'(m);
      for (int i = -500; i < 500; i += 111)
        for (int q = -500; q < 500; q += 97)
          send(m == 1 ? "R4 usb" : "R5 lsb", i, q);
    end

    // R10 phase offset
    disable_nco();
    nco_en = 1'b1; ftw = '0; mode = 3'b001; phase_ofs = 16'h4000;
    @(negedge clk);
    send("R10 offset 90", 300, 100);
    chk_exact("R10 A equals -Q", int'(out_a), -100);
    chk_exact("R10 B equals I", int'(out_b), 300);
    phase_ofs = 16'h8000;
    send("R10 offset 180", 250, -60);

    // R9 saturation at 45 degrees
    phase_ofs = 16'h2000;
    send("R9 sat low", -512, -512);
    chk_exact("R9 clamp B min", int'(out_b), -512);
    send("R9 sat high", 511, 511);
    chk_exact("R9 clamp B max", int'(out_b), 511);
    mode = 3'b010;
    send("R9 R5 sat", 511, -512);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule